// File: doc/BRIEF.md
# FIFO Flag Threshold Offset Programmer

This block keeps the two threshold offsets that a FIFO's programmable flags compare against. One offset gives the distance from the empty boundary at which the almost-empty flag switches. The other gives the distance from the full boundary at which the almost-full flag switches. Both offsets drive the flag comparators directly.

At master reset the level of a shared load pin picks a preset pair and an entry method:
- **Load pin low:** both offsets become 127 and parallel entry is chosen.
- **Load pin high:** both offsets become 1023 and serial entry is chosen.

Either preset is clamped to DEPTH-1 when the FIFO is smaller. After reset, software reprograms the offsets through the chosen method. Serial entry takes one bit per write-clock edge. Parallel entry takes one word per write-clock edge. On the read clock, the offsets can be read back in parallel whichever method was chosen.

A partial reset rewinds all sequencing. It keeps the offsets and the entry method. Offset contents move to the read side by plain synchronous handoff: they must be quiet while they are read back.

Top module: `ofs_prog_unit`

## Requirements
- R1: A master reset sampled with `ldIn` low sets both offsets to min(127, DEPTH-1) and selects parallel entry.
- R2: A master reset sampled with `ldIn` high sets both offsets to min(1023, DEPTH-1) and selects serial entry.
- R3: In parallel mode, each write-clock edge with `wenIn` and `ldIn` high stores `dIn`. Stores alternate between the two offsets: the almost-empty offset first, then the almost-full offset, then the almost-empty offset again.
- R4: In serial mode, each write-clock edge with `senIn` and `ldIn` high shifts in `siIn`, LSB first.
  - The first OW bits form the almost-empty offset and the next OW bits form the almost-full offset. The sequence then wraps.
  - An offset output changes only on the edge that delivers its last bit.
- R5: Serial entry strobes have no effect in parallel mode. Parallel entry strobes have no effect in serial mode.
- R6: Each read-clock edge with `renIn` and `ldIn` high drives one offset onto `qOut`. Reads alternate: the almost-empty offset first, then the almost-full offset.
  - `qOut` shows the value the offset held before that edge.
  - Between reads, `qOut` holds.
  - Readback works in both modes.
- R7: A partial reset leaves both offsets and the entry method unchanged. It returns the parallel write sequence, the serial bit position and the read sequence to the almost-empty offset.
- R8: A master reset also returns all three sequences to the start and clears `qOut` to 0.
- R9: While `ldIn` is low, `wenIn`, `senIn` and `renIn` change neither the offsets nor `qOut`.
- R10: Master reset takes precedence over partial reset. Partial reset takes precedence over any load or read on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mstRst | input | 1 | Master reset, active high, synchronous |
| partRst | input | 1 | Partial reset, active high, synchronous |
| ldIn | input | 1 | Shared load pin: preset select at reset, qualifier otherwise |
| wenIn | input | 1 | Parallel entry strobe |
| senIn | input | 1 | Serial entry strobe |
| siIn | input | 1 | Serial data bit |
| dIn | input | OW | Parallel data word |
| renIn | input | 1 | Readback strobe |
| qOut | output | OW | Readback data |
| aeOfs | output | OW | Almost-empty threshold offset |
| afOfs | output | OW | Almost-full threshold offset |

## Verification
A parallel store and a readback can land on the same edge when both clocks run in step. The bench provokes this directly: it stores a new word and reads the same offset on one edge. Random traffic also raises both strobes together often. The judgement is that `qOut` must carry the old offset while the offset output already shows the new word. Serial commits that coincide with readback are judged the same way.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

  typedef struct packed {
    logic presetHi;
    logic presetLo;
    logic loadAe;
    logic loadAf;
    logic shiftEn;
    logic commitAe;
    logic commitAf;
  } wrStb_t;

  typedef struct packed {
    logic rdStrobe;
    logic rdSelAf;
    logic rdClear;
  } rdStb_t;

  function automatic int satDflt(input int val, input int depth);
    return (val > depth - 1) ? depth - 1 : val;
  endfunction

endpackage

// File: rtl/ofs_ctrl.sv
module ofs_ctrl
  import ofs_pkg::*;
#(
  parameter int OW = 12
) (
  input  logic   wclk,
  input  logic   rclk,
  input  logic   mstRst,
  input  logic   partRst,
  input  logic   ldIn,
  input  logic   wenIn,
  input  logic   senIn,
  input  logic   renIn,
  output wrStb_t wStb,
  output rdStb_t rStb
);
  localparam int CW = $clog2(2 * OW);
  localparam logic [CW-1:0] AE_LAST = CW'(OW - 1);
  localparam logic [CW-1:0] AF_LAST = CW'(2 * OW - 1);

  logic          serialMode;
  logic          wPtr;
  logic          rPtr;
  logic [CW-1:0] bitCnt;
  logic          opOk;
  logic          parWr;
  logic          serWr;
  logic          lastBit;

  always_comb begin
    opOk    = !mstRst && !partRst;
    parWr   = opOk && !serialMode && wenIn && ldIn;
    serWr   = opOk && serialMode && senIn && ldIn;
    lastBit = (bitCnt == AF_LAST);
    wStb.presetHi = mstRst && ldIn;
    wStb.presetLo = mstRst && !ldIn;
    wStb.loadAe   = parWr && !wPtr;
    wStb.loadAf   = parWr && wPtr;
    wStb.shiftEn  = serWr;
    wStb.commitAe = serWr && (bitCnt == AE_LAST);
    wStb.commitAf = serWr && lastBit;
    rStb.rdStrobe = opOk && renIn && ldIn;
    rStb.rdSelAf  = rPtr;
    rStb.rdClear  = mstRst;
  end

  always_ff @(posedge wclk) begin
    if (mstRst) begin
      serialMode <= ldIn;
      wPtr       <= 1'b0;
      bitCnt     <= '0;
    end else if (partRst) begin
      wPtr   <= 1'b0;
      bitCnt <= '0;
    end else begin
      if (parWr) wPtr <= ~wPtr;
      if (serWr) bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
    end
  end

  always_ff @(posedge rclk) begin
    if (mstRst || partRst) rPtr <= 1'b0;
    else if (rStb.rdStrobe) rPtr <= ~rPtr;
  end

  // R4: the serial bit position never leaves the two-register window
  a_r4_cnt_range: assert property (@(posedge wclk) disable iff (mstRst)
    bitCnt <= AF_LAST);

  // R7: the entry method only moves on a master reset
  a_r7_mode_kept: assert property (@(posedge wclk) disable iff (mstRst)
    !mstRst |=> $stable(serialMode));

endmodule

// File: rtl/ofs_data.sv
module ofs_data
  import ofs_pkg::*;
#(
  parameter int DEPTH = 4096,
  parameter int OW    = 12
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          siIn,
  input  logic [OW-1:0] dIn,
  input  wrStb_t        wStb,
  input  rdStb_t        rStb,
  output logic [OW-1:0] aeOfs,
  output logic [OW-1:0] afOfs,
  output logic [OW-1:0] qOut
);
  localparam logic [OW-1:0] DFLT_LO = OW'(satDflt(127, DEPTH));
  localparam logic [OW-1:0] DFLT_HI = OW'(satDflt(1023, DEPTH));

  logic [OW-1:0] shiftReg;
  logic [OW-1:0] shiftNext;

  assign shiftNext = {siIn, shiftReg[OW-1:1]};

  always_ff @(posedge wclk) begin
    if (wStb.presetHi) begin
      aeOfs <= DFLT_HI;
      afOfs <= DFLT_HI;
    end else if (wStb.presetLo) begin
      aeOfs <= DFLT_LO;
      afOfs <= DFLT_LO;
    end else begin
      if (wStb.loadAe)   aeOfs <= dIn;
      if (wStb.commitAe) aeOfs <= shiftNext;
      if (wStb.loadAf)   afOfs <= dIn;
      if (wStb.commitAf) afOfs <= shiftNext;
    end
    if (wStb.shiftEn) shiftReg <= shiftNext;
  end

  always_ff @(posedge rclk) begin
    if (rStb.rdClear) qOut <= '0;
    else if (rStb.rdStrobe) qOut <= rStb.rdSelAf ? afOfs : aeOfs;
  end

  // R3: at most one offset update source is active on an edge
  a_r3_one_update: assert property (@(posedge wclk)
    disable iff (wStb.presetHi || wStb.presetLo)
    $onehot0({wStb.loadAe, wStb.loadAf, wStb.commitAe, wStb.commitAf}));

  // R4: a serial shift without a commit leaves both offsets alone
  a_r4_no_early: assert property (@(posedge wclk)
    disable iff (wStb.presetHi || wStb.presetLo)
    (wStb.shiftEn && !wStb.commitAe && !wStb.commitAf)
      |=> ($stable(aeOfs) && $stable(afOfs)));

  // R6: readback carries the pre-edge value of the selected offset
  a_r6_readback: assert property (@(posedge rclk) disable iff (rStb.rdClear)
    rStb.rdStrobe |=> (qOut == $past(rStb.rdSelAf ? afOfs : aeOfs)));

endmodule

// File: rtl/ofs_prog_unit.sv
module ofs_prog_unit
  import ofs_pkg::*;
#(
  parameter  int DEPTH = 4096,
  localparam int OW    = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mstRst,
  input  logic          partRst,
  input  logic          ldIn,
  input  logic          wenIn,
  input  logic          senIn,
  input  logic          siIn,
  input  logic [OW-1:0] dIn,
  input  logic          renIn,
  output logic [OW-1:0] qOut,
  output logic [OW-1:0] aeOfs,
  output logic [OW-1:0] afOfs
);
  localparam logic [OW-1:0] TOP_LO = OW'(satDflt(127, DEPTH));
  localparam logic [OW-1:0] TOP_HI = OW'(satDflt(1023, DEPTH));

  wrStb_t wStb;
  rdStb_t rStb;

  ofs_ctrl #(.OW(OW)) uCtrl (
    .wclk(wclk), .rclk(rclk), .mstRst(mstRst), .partRst(partRst),
    .ldIn(ldIn), .wenIn(wenIn), .senIn(senIn), .renIn(renIn),
    .wStb(wStb), .rStb(rStb)
  );

  ofs_data #(.DEPTH(DEPTH), .OW(OW)) uData (
    .wclk(wclk), .rclk(rclk), .siIn(siIn), .dIn(dIn),
    .wStb(wStb), .rStb(rStb),
    .aeOfs(aeOfs), .afOfs(afOfs), .qOut(qOut)
  );

  // R1: low-level preset after master reset
  a_r1_preset_lo: assert property (@(posedge wclk) disable iff (mstRst)
    ($fell(mstRst) && !$past(ldIn)) |-> (aeOfs == TOP_LO && afOfs == TOP_LO));

  // R2: high-level preset after master reset
  a_r2_preset_hi: assert property (@(posedge wclk) disable iff (mstRst)
    ($fell(mstRst) && $past(ldIn)) |-> (aeOfs == TOP_HI && afOfs == TOP_HI));

  // R7: partial reset keeps both offsets
  a_r7_part_keeps: assert property (@(posedge wclk) disable iff (mstRst)
    partRst |=> ($stable(aeOfs) && $stable(afOfs)));

endmodule

// File: tb/tb_ofs_prog_unit.sv
module tb_ofs_prog_unit;
  localparam int DEPTH = 4096;
  localparam int OW = $clog2(DEPTH);
  localparam int SOW = 9;

  logic clk = 1'b0;
  logic mstRst = 1'b1, partRst = 1'b0, ldIn = 1'b0, wenIn = 1'b0;
  logic senIn = 1'b0, siIn = 1'b0, renIn = 1'b0;
  logic [OW-1:0] dIn = '0;
  logic [OW-1:0] qOut, aeOfs, afOfs;
  logic [SOW-1:0] qS, aeS, afS;

  int tests = 0, fails = 0;

  logic [OW-1:0] mAe, mAf, mQ, mSh;
  bit mSer, mW, mR;
  int mCnt;

  always #2 clk = ~clk;

  ofs_prog_unit #(.DEPTH(DEPTH)) dut (
    .wclk(clk), .rclk(clk), .mstRst(mstRst), .partRst(partRst), .ldIn(ldIn),
    .wenIn(wenIn), .senIn(senIn), .siIn(siIn), .dIn(dIn), .renIn(renIn),
    .qOut(qOut), .aeOfs(aeOfs), .afOfs(afOfs));

  ofs_prog_unit #(.DEPTH(512)) dutSmall (
    .wclk(clk), .rclk(clk), .mstRst(mstRst), .partRst(partRst), .ldIn(ldIn),
    .wenIn(wenIn), .senIn(senIn), .siIn(siIn), .dIn(dIn[SOW-1:0]), .renIn(renIn),
    .qOut(qS), .aeOfs(aeS), .afOfs(afS));

  function automatic logic [OW-1:0] dflt(input bit hi, input int depth);
    int v = hi ? 1023 : 127;
    return OW'((v > depth - 1) ? depth - 1 : v);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model(input bit m, p, l, w, s, si, r, input logic [OW-1:0] d);
    if (m) begin
      mSer = l; mAe = dflt(l, DEPTH); mAf = mAe;
      mW = 0; mR = 0; mCnt = 0; mQ = '0;
    end else if (p) begin
      mW = 0; mR = 0; mCnt = 0;
    end else begin
      if (r && l) begin mQ = mR ? mAf : mAe; mR = !mR; end
      if (!mSer && w && l) begin
        if (!mW) mAe = d; else mAf = d;
        mW = !mW;
      end
      if (mSer && s && l) begin
        mSh = {si, mSh[OW-1:1]};
        if (mCnt == OW - 1) mAe = mSh;
        if (mCnt == 2 * OW - 1) mAf = mSh;
        mCnt = (mCnt == 2 * OW - 1) ? 0 : mCnt + 1;
      end
    end
  endtask

  task automatic step(input bit m, p, l, w, s, si, r, input logic [OW-1:0] d);
    string tg;
    @(negedge clk);
    mstRst = m; partRst = p; ldIn = l; wenIn = w; senIn = s; siIn = si; renIn = r; dIn = d;
    @(posedge clk);
    model(m, p, l, w, s, si, r, d);
    #1;
    tg = m ? (l ? "R2" : "R1") : p ? "R7" : !l ? "R9" : mSer ? "R4/R5" : "R3/R5";
    check(aeOfs == mAe, {tg, " aeOfs"}, aeOfs, mAe);
    check(afOfs == mAf, {tg, " afOfs"}, afOfs, mAf);
    check(qOut == mQ, (m ? "R8 qOut" : (r && l && !p) ? "R6 qOut" : "R9 qOut"), qOut, mQ);
  endtask

  task automatic serialWord(input logic [OW-1:0] v);
    for (int i = 0; i < OW; i++) step(0, 0, 1, 0, 1, v[i], 0, '0);
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finishRun();
  end

  initial begin
    logic [OW-1:0] keepAe;
    mSh = '0;
    void'($urandom(32'd20240611));
    // R1: preset low, parallel mode
    step(1, 0, 0, 0, 0, 0, 0, '0);
    step(1, 0, 0, 0, 0, 0, 0, '0);
    check(aeOfs == 12'd127, "R1 preset", aeOfs, 127);
    check(aeS == 9'd127 && afS == 9'd127, "R1 small preset", aeS, 127);
    check(qOut == '0, "R8 qOut cleared", qOut, 0);
    // R3: two parallel stores
    step(0, 0, 1, 1, 0, 0, 0, 12'h123);
    step(0, 0, 1, 1, 0, 0, 0, 12'h456);
    check(aeOfs == 12'h123 && afOfs == 12'h456, "R3 order", afOfs, 12'h456);
    // R5: serial strobes ignored in parallel mode
    for (int i = 0; i < 2 * OW; i++) step(0, 0, 1, 0, 1, 1'b1, 0, '0);
    check(aeOfs == 12'h123, "R5 serial ignored", aeOfs, 12'h123);
    // R9: strobes without ldIn
    step(0, 0, 0, 1, 1, 1, 1, 12'hFFF);
    // R6: readback order, then store and read on one edge
    step(0, 0, 1, 0, 0, 0, 1, '0);
    check(qOut == 12'h123, "R6 first read", qOut, 12'h123);
    step(0, 0, 1, 0, 0, 0, 1, '0);
    check(qOut == 12'h456, "R6 second read", qOut, 12'h456);
    step(0, 0, 1, 1, 0, 0, 1, 12'h777);
    check(qOut == 12'h123 && aeOfs == 12'h777, "R6 same-edge old value", qOut, 12'h123);
    // R7: partial reset keeps offsets and restarts sequences
    step(0, 0, 1, 1, 0, 0, 0, 12'h0AA);
    keepAe = aeOfs;
    step(0, 1, 1, 1, 0, 0, 1, 12'h555);
    check(aeOfs == keepAe && afOfs == 12'h0AA, "R7 offsets kept", afOfs, 12'h0AA);
    step(0, 0, 1, 0, 0, 0, 1, '0);
    check(qOut == keepAe, "R7 read restart", qOut, keepAe);
    step(0, 0, 1, 1, 0, 0, 0, 12'h321);
    check(aeOfs == 12'h321, "R7 write restart", aeOfs, 12'h321);
    // R2: preset high, serial mode; clamp in small instance
    step(1, 0, 1, 0, 0, 0, 0, '0);
    check(aeOfs == 12'd1023 && afOfs == 12'd1023, "R2 preset", aeOfs, 1023);
    check(aeS == 9'd511 && afS == 9'd511, "R2 small clamp", aeS, 511);
    // R5: parallel store ignored in serial mode
    step(0, 0, 1, 1, 0, 0, 0, 12'h001);
    check(aeOfs == 12'd1023, "R5 parallel ignored", aeOfs, 1023);
    // R4: serial words, LSB first
    serialWord(12'hA5C);
    check(aeOfs == 12'hA5C && afOfs == 12'd1023, "R4 first word", aeOfs, 12'hA5C);
    serialWord(12'h3E1);
    check(afOfs == 12'h3E1, "R4 second word", afOfs, 12'h3E1);
    // R7: partial reset mid-word keeps mode and restarts bit count
    for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 1, 1'b1, 0, '0);
    step(0, 1, 1, 0, 1, 0, 0, '0);
    serialWord(12'h00F);
    check(aeOfs == 12'h00F, "R7 serial restart", aeOfs, 12'h00F);
    // R10: master and partial reset together
    step(1, 1, 0, 1, 1, 1, 1, 12'hFFF);
    check(aeOfs == 12'd127 && qOut == '0, "R10 master wins", aeOfs, 127);
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      bit m = ($urandom % 97) == 0;
      bit p = ($urandom % 41) == 0;
      step(m, p, $urandom % 4 != 0, $urandom % 2, $urandom % 2, $urandom % 2,
           $urandom % 2, OW'($urandom));
    end
    finishRun();
  end
endmodule